// File: doc/BRIEF.md
# Receive Message Object Allocator with Interrupt Identifier

This block sits between the protocol engine of a CAN controller and its bank of message objects. When the protocol side presents a received frame, the block compares the frame's identifier and format flag against every valid object. Masking is applied per object. The frame is placed in the lowest-numbered eligible object, and that object's status flags are updated. Objects sharing one filter form a receive queue. An object with new data is passed over until the object carrying the end-of-chain flag is reached. That last object is overwritten when everything before it is full, and the loss is recorded.

The block also exports, for all objects, vectors of new-data, interrupt-pending, message-lost and transmit-request flags. It forms the interrupt identifier: status events take precedence, and otherwise it gives the number of the lowest pending object. Software sets objects up through a configuration write port and acknowledges them through a clear port. It reads back stored frames through a combinational read port.

Top module: `rxobj_alloc`

## Requirements
- R1: After reset every summary vector (new-data, pending, lost, transmit-request) is zero and the interrupt identifier reads 0.
- R2: A data frame matches an object only when that object is valid and set to receive direction (dir_tx=0), and, for each identifier bit and the extended flag, the received value equals the stored one. Every bit is compared when use-mask is 0; with use-mask 1 only bits whose mask bit is 1 are compared.
- R3: A stored frame sets the new-data flag of the chosen object. Its identifier, extended flag, length and payload become readable at the read port. Object index i (ports cfg_obj, clr_obj, rd_obj) is object number i+1 and is bit i of every summary vector.
- R4: Among matching objects, one with new data and no end-of-chain flag is skipped. The frame goes to the lowest matching object that is either free or carries the end-of-chain flag. It sets the lost flag only when that object already held new data.
- R5: If every matching object is full and none carries the end-of-chain flag, the frame is dropped and no object changes.
- R6: The pending flag is set on storage only when the object's receive interrupt enable is 1; new-data is set regardless.
- R7: While the status interrupt input is high, the interrupt identifier reads 0x8000.
- R8: Otherwise the identifier reads the number (index+1) of the lowest-numbered pending object, or 0 when none is pending. It follows changes in the pending flags in the same cycle.
- R9: A remote frame matches only valid transmit-direction objects (dir_tx=1) under the same identifier rule. It sets the transmit-request flag of the lowest match, and it writes no payload and no new-data flag.
- R10: A clear request on clr_obj drops the flags selected in clr_bits: bit 0 new-data, bit 1 pending, bit 2 lost, bit 3 transmit-request. A frame stored to the same object in the same cycle takes precedence.
- R11: A configuration write loads the object's filter and control fields and zeroes its new-data, pending, lost and transmit-request flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_obj | input | IDX_W | Object index written |
| cfg_msgval | input | 1 | Object valid |
| cfg_dir_tx | input | 1 | 1 = transmit direction, 0 = receive |
| cfg_xtd | input | 1 | Stored extended flag |
| cfg_id | input | 29 | Stored identifier |
| cfg_mask_id | input | 29 | Identifier compare mask |
| cfg_mask_xtd | input | 1 | Extended-flag compare mask |
| cfg_umask | input | 1 | Use the masks |
| cfg_rxie | input | 1 | Receive interrupt enable |
| cfg_eob | input | 1 | End-of-chain flag |
| clr_valid | input | 1 | Clear strobe |
| clr_obj | input | IDX_W | Object index cleared |
| clr_bits | input | 4 | Flags to clear (see R10) |
| rx_valid | input | 1 | Received frame strobe |
| rx_id | input | 29 | Received identifier |
| rx_xtd | input | 1 | Received extended flag |
| rx_rtr | input | 1 | Received frame is a remote frame |
| rx_dlc | input | 4 | Received length code |
| rx_data | input | DATA_W | Received payload |
| stat_irq | input | 1 | Status interrupt request |
| rd_obj | input | IDX_W | Object index read back |
| rd_id | output | 29 | Identifier of rd_obj |
| rd_xtd | output | 1 | Extended flag of rd_obj |
| rd_dlc | output | 4 | Length code of rd_obj |
| rd_data | output | DATA_W | Payload of rd_obj |
| newdat_vec | output | NUM_OBJ | New-data flags |
| intpnd_vec | output | NUM_OBJ | Interrupt-pending flags |
| msglst_vec | output | NUM_OBJ | Message-lost flags |
| txrqst_vec | output | NUM_OBJ | Transmit-request flags |
| int_id | output | 16 | Interrupt identifier |

## Verification
Exact-identifier frames with and without a near neighbour show that the compare is bit-exact. Masked frames that differ in don't-care bits, in the extended flag, and frames aimed at an invalid object separate the mask, format and valid conditions. A three-deep queue filled to four frames separates skipping from overwriting, and a full object with no end-of-chain flag shows dropping. Pairs of pending objects with and without the status input, a remote frame against a transmit and a receive object with the same identifier, and a reconfiguration after storage tell priority, direction and flag reset apart.

// File: rtl/rxobj_pkg.sv
package rxobj_pkg;
  localparam int ID_W = 29;

  typedef struct packed {
    logic            msgval;
    logic            dir_tx;
    logic            xtd;
    logic [ID_W-1:0] id;
    logic [ID_W-1:0] mask_id;
    logic            mask_xtd;
    logic            umask;
    logic            rxie;
    logic            eob;
  } obj_cfg_t;

  // Masked identifier and format compare for one object.
  function automatic logic id_hit(input obj_cfg_t c,
                                  input logic [ID_W-1:0] rid,
                                  input logic rxtd);
    logic [ID_W-1:0] m;
    logic            mx;
    m  = c.umask ? c.mask_id  : {ID_W{1'b1}};
    mx = c.umask ? c.mask_xtd : 1'b1;
    return (((rid ^ c.id) & m) == '0) && (((rxtd ^ c.xtd) & mx) == 1'b0);
  endfunction
endpackage

// File: rtl/rxo_match.sv
module rxo_match
  import rxobj_pkg::*;
#(
  parameter int N = 32
) (
  input  obj_cfg_t [N-1:0] cfg,
  input  logic [ID_W-1:0]  rx_id,
  input  logic             rx_xtd,
  input  logic             rx_rtr,
  output logic [N-1:0]     hit
);
  // Data frames look for receive objects, remote frames for transmit ones.
  for (genvar i = 0; i < N; i++) begin : g_obj
    assign hit[i] = cfg[i].msgval && (cfg[i].dir_tx == rx_rtr) &&
                    id_hit(cfg[i], rx_id, rx_xtd);
  end
endmodule

// File: rtl/rxo_pick.sv
module rxo_pick #(
  parameter  int N  = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  // R4 / R8: chosen index is a requester and nothing below it requests
  a_r4_pick_is_req: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> req[idx]);
  a_r8_pick_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ((req & ((N'(1) << idx) - N'(1))) == '0));
endmodule

// File: rtl/rxo_intid.sv
module rxo_intid #(
  parameter  int N  = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stat_irq,
  input  logic [N-1:0] pend,
  output logic [15:0]  int_id
);
  logic          any_pend;
  logic [IW-1:0] low_idx;

  rxo_pick #(.N(N)) u_low (
    .clk(clk), .rst_n(rst_n), .req(pend), .found(any_pend), .idx(low_idx)
  );

  always_comb begin
    if (stat_irq)      int_id = 16'h8000;
    else if (any_pend) int_id = 16'(low_idx) + 16'd1;
    else               int_id = 16'd0;
  end
endmodule

// File: rtl/rxobj_alloc.sv
module rxobj_alloc
  import rxobj_pkg::*;
#(
  parameter  int NUM_OBJ = 32,
  parameter  int DATA_W  = 64,
  localparam int IDX_W   = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_valid,
  input  logic [IDX_W-1:0]   cfg_obj,
  input  logic               cfg_msgval,
  input  logic               cfg_dir_tx,
  input  logic               cfg_xtd,
  input  logic [ID_W-1:0]    cfg_id,
  input  logic [ID_W-1:0]    cfg_mask_id,
  input  logic               cfg_mask_xtd,
  input  logic               cfg_umask,
  input  logic               cfg_rxie,
  input  logic               cfg_eob,
  input  logic               clr_valid,
  input  logic [IDX_W-1:0]   clr_obj,
  input  logic [3:0]         clr_bits,
  input  logic               rx_valid,
  input  logic [ID_W-1:0]    rx_id,
  input  logic               rx_xtd,
  input  logic               rx_rtr,
  input  logic [3:0]         rx_dlc,
  input  logic [DATA_W-1:0]  rx_data,
  input  logic               stat_irq,
  input  logic [IDX_W-1:0]   rd_obj,
  output logic [ID_W-1:0]    rd_id,
  output logic               rd_xtd,
  output logic [3:0]         rd_dlc,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NUM_OBJ-1:0] newdat_vec,
  output logic [NUM_OBJ-1:0] intpnd_vec,
  output logic [NUM_OBJ-1:0] msglst_vec,
  output logic [NUM_OBJ-1:0] txrqst_vec,
  output logic [15:0]        int_id
);
  obj_cfg_t [NUM_OBJ-1:0] cfg_q;
  logic [NUM_OBJ-1:0]     newdat_q, intpnd_q, msglst_q, txrqst_q;
  logic [3:0]             dlc_q  [NUM_OBJ];
  logic [DATA_W-1:0]      data_q [NUM_OBJ];

  obj_cfg_t               cfg_in;
  logic [NUM_OBJ-1:0]     hit, eob_vec, cand;
  logic                   sel_found;
  logic [IDX_W-1:0]       sel_idx;
  logic                   store_fire, remote_fire;

  always_comb begin
    cfg_in.msgval   = cfg_msgval;
    cfg_in.dir_tx   = cfg_dir_tx;
    cfg_in.xtd      = cfg_xtd;
    cfg_in.id       = cfg_id;
    cfg_in.mask_id  = cfg_mask_id;
    cfg_in.mask_xtd = cfg_mask_xtd;
    cfg_in.umask    = cfg_umask;
    cfg_in.rxie     = cfg_rxie;
    cfg_in.eob      = cfg_eob;
  end

  rxo_match #(.N(NUM_OBJ)) u_match (
    .cfg(cfg_q), .rx_id(rx_id), .rx_xtd(rx_xtd), .rx_rtr(rx_rtr), .hit(hit)
  );

  for (genvar i = 0; i < NUM_OBJ; i++) begin : g_eob
    assign eob_vec[i] = cfg_q[i].eob;
  end

  // A full object is passed over unless it closes its chain.
  assign cand = rx_rtr ? hit : (hit & (~newdat_q | eob_vec));

  rxo_pick #(.N(NUM_OBJ)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(cand), .found(sel_found), .idx(sel_idx)
  );

  assign store_fire  = rx_valid && sel_found && !rx_rtr;
  assign remote_fire = rx_valid && sel_found &&  rx_rtr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      newdat_q <= '0;
      intpnd_q <= '0;
      msglst_q <= '0;
      txrqst_q <= '0;
      for (int i = 0; i < NUM_OBJ; i++) begin
        dlc_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      if (cfg_valid) begin
        cfg_q[cfg_obj]    <= cfg_in;
        newdat_q[cfg_obj] <= 1'b0;
        intpnd_q[cfg_obj] <= 1'b0;
        msglst_q[cfg_obj] <= 1'b0;
        txrqst_q[cfg_obj] <= 1'b0;
      end
      if (clr_valid) begin
        if (clr_bits[0]) newdat_q[clr_obj] <= 1'b0;
        if (clr_bits[1]) intpnd_q[clr_obj] <= 1'b0;
        if (clr_bits[2]) msglst_q[clr_obj] <= 1'b0;
        if (clr_bits[3]) txrqst_q[clr_obj] <= 1'b0;
      end
      if (store_fire) begin
        newdat_q[sel_idx]   <= 1'b1;
        intpnd_q[sel_idx]   <= intpnd_q[sel_idx] | cfg_q[sel_idx].rxie;
        msglst_q[sel_idx]   <= msglst_q[sel_idx] | newdat_q[sel_idx];
        cfg_q[sel_idx].id   <= rx_id;
        cfg_q[sel_idx].xtd  <= rx_xtd;
        dlc_q[sel_idx]      <= rx_dlc;
        data_q[sel_idx]     <= rx_data;
      end
      if (remote_fire) begin
        txrqst_q[sel_idx] <= 1'b1;
      end
    end
  end

  rxo_intid #(.N(NUM_OBJ)) u_intid (
    .clk(clk), .rst_n(rst_n), .stat_irq(stat_irq), .pend(intpnd_q), .int_id(int_id)
  );

  assign rd_id      = cfg_q[rd_obj].id;
  assign rd_xtd     = cfg_q[rd_obj].xtd;
  assign rd_dlc     = dlc_q[rd_obj];
  assign rd_data    = data_q[rd_obj];
  assign newdat_vec = newdat_q;
  assign intpnd_vec = intpnd_q;
  assign msglst_vec = msglst_q;
  assign txrqst_vec = txrqst_q;

  // R3: storage leaves new data in the chosen object
  a_r3_store_newdat: assert property (@(posedge clk) disable iff (!rst_n)
    store_fire |=> newdat_q[$past(sel_idx)]);
  // R4: overwriting a full object records the loss
  a_r4_overwrite_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (store_fire && newdat_q[sel_idx]) |=> msglst_q[$past(sel_idx)]);
  // R5: an unplaceable data frame changes nothing
  a_r5_drop_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_rtr && !sel_found && !cfg_valid && !clr_valid)
      |=> ($stable(newdat_q) && $stable(msglst_q) && $stable(intpnd_q)));
  // R6: without interrupt enable no pending flag appears
  a_r6_rxie_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (store_fire && !cfg_q[sel_idx].rxie && !intpnd_q[sel_idx])
      |=> !intpnd_q[$past(sel_idx)]);
  // R7: status events win the identifier
  a_r7_status_first: assert property (@(posedge clk) disable iff (!rst_n)
    stat_irq |-> (int_id == 16'h8000));
  // R8: identifier names a pending object or nothing
  a_r8_id_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_irq && int_id != 16'd0) |-> intpnd_q[IDX_W'(int_id - 16'd1)]);
  a_r8_id_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_irq && intpnd_q == '0) |-> (int_id == 16'd0));
  // R9: remote frames raise a request and leave new data alone
  a_r9_remote: assert property (@(posedge clk) disable iff (!rst_n)
    (remote_fire && !cfg_valid && !clr_valid)
      |=> ($stable(newdat_q) && txrqst_q[$past(sel_idx)]));
endmodule

// File: tb/tb_rxobj_alloc.sv
module tb_rxobj_alloc;
  localparam int N  = 32;
  localparam int DW = 64;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_valid = 0, cfg_msgval = 0, cfg_dir_tx = 0, cfg_xtd = 0;
  logic [IW-1:0] cfg_obj = '0;
  logic [28:0]   cfg_id = '0, cfg_mask_id = '0;
  logic          cfg_mask_xtd = 0, cfg_umask = 0, cfg_rxie = 0, cfg_eob = 0;
  logic          clr_valid = 0;
  logic [IW-1:0] clr_obj = '0;
  logic [3:0]    clr_bits = '0;
  logic          rx_valid = 0, rx_xtd = 0, rx_rtr = 0;
  logic [28:0]   rx_id = '0;
  logic [3:0]    rx_dlc = '0;
  logic [DW-1:0] rx_data = '0;
  logic          stat_irq = 0;
  logic [IW-1:0] rd_obj = '0;
  logic [28:0]   rd_id;
  logic          rd_xtd;
  logic [3:0]    rd_dlc;
  logic [DW-1:0] rd_data;
  logic [N-1:0]  newdat_vec, intpnd_vec, msglst_vec, txrqst_vec;
  logic [15:0]   int_id;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  rxobj_alloc dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_obj(cfg_obj), .cfg_msgval(cfg_msgval),
    .cfg_dir_tx(cfg_dir_tx), .cfg_xtd(cfg_xtd), .cfg_id(cfg_id),
    .cfg_mask_id(cfg_mask_id), .cfg_mask_xtd(cfg_mask_xtd), .cfg_umask(cfg_umask),
    .cfg_rxie(cfg_rxie), .cfg_eob(cfg_eob),
    .clr_valid(clr_valid), .clr_obj(clr_obj), .clr_bits(clr_bits),
    .rx_valid(rx_valid), .rx_id(rx_id), .rx_xtd(rx_xtd), .rx_rtr(rx_rtr),
    .rx_dlc(rx_dlc), .rx_data(rx_data), .stat_irq(stat_irq),
    .rd_obj(rd_obj), .rd_id(rd_id), .rd_xtd(rd_xtd), .rd_dlc(rd_dlc), .rd_data(rd_data),
    .newdat_vec(newdat_vec), .intpnd_vec(intpnd_vec), .msglst_vec(msglst_vec),
    .txrqst_vec(txrqst_vec), .int_id(int_id)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_obj(input int idx, input logic dir_tx, input logic [28:0] id,
                         input logic umask, input logic [28:0] mask, input logic rxie,
                         input logic eob, input logic msgval = 1'b1,
                         input logic xtd = 1'b0, input logic mxtd = 1'b1);
    @(negedge clk);
    cfg_valid = 1; cfg_obj = IW'(idx); cfg_msgval = msgval; cfg_dir_tx = dir_tx;
    cfg_xtd = xtd; cfg_id = id; cfg_umask = umask; cfg_mask_id = mask;
    cfg_mask_xtd = mxtd; cfg_rxie = rxie; cfg_eob = eob;
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic send(input logic [28:0] id, input logic xtd, input logic rtr,
                      input logic [3:0] dlc, input logic [63:0] data);
    @(negedge clk);
    rx_valid = 1; rx_id = id; rx_xtd = xtd; rx_rtr = rtr; rx_dlc = dlc; rx_data = data;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic clear(input int idx, input logic [3:0] bits);
    @(negedge clk);
    clr_valid = 1; clr_obj = IW'(idx); clr_bits = bits;
    @(negedge clk);
    clr_valid = 0;
  endtask

  task automatic peek(input int idx);
    rd_obj = IW'(idx);
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 newdat", 64'(newdat_vec), 64'h0);
    chk("R1 intpnd", 64'(intpnd_vec), 64'h0);
    chk("R1 msglst", 64'(msglst_vec), 64'h0);
    chk("R1 txrqst", 64'(txrqst_vec), 64'h0);
    chk("R1 int_id", 64'(int_id), 64'h0);
  endtask

  task automatic t_exact();
    do_reset();
    set_obj(1, 0, 29'h124, 0, '0, 1, 1);
    set_obj(2, 0, 29'h123, 0, '0, 1, 1);
    send(29'h123, 0, 0, 4'd8, 64'h1122334455667788);
    chk("R2 exact newdat", 64'(newdat_vec), 64'h4);
    chk("R3 intpnd", 64'(intpnd_vec), 64'h4);
    chk("R8 int_id obj3", 64'(int_id), 64'd3);
    peek(2);
    chk("R3 data", rd_data, 64'h1122334455667788);
    chk("R3 dlc", 64'(rd_dlc), 64'd8);
    chk("R3 id", 64'(rd_id), 64'h123);
  endtask

  task automatic t_mask();
    do_reset();
    set_obj(0, 0, 29'h120, 1, 29'h1FFFFFF0, 1, 1);
    set_obj(5, 0, 29'h130, 0, '0, 1, 1, 1'b0);
    send(29'h12F, 0, 0, 4'd2, 64'hAB);
    chk("R2 masked hit", 64'(newdat_vec), 64'h1);
    send(29'h12E, 1, 0, 4'd2, 64'hCD);
    chk("R2 xtd mismatch msglst", 64'(msglst_vec), 64'h0);
    peek(0);
    chk("R2 xtd mismatch data", rd_data, 64'hAB);
    send(29'h130, 0, 0, 4'd1, 64'hEE);
    chk("R2 invalid obj ignored", 64'(newdat_vec), 64'h1);
  endtask

  task automatic t_fifo();
    do_reset();
    for (int i = 4; i <= 6; i++) set_obj(i, 0, 29'h055, 0, '0, 1, i == 6);
    send(29'h055, 0, 0, 4'd1, 64'hA);
    send(29'h055, 0, 0, 4'd1, 64'hB);
    send(29'h055, 0, 0, 4'd1, 64'hC);
    chk("R4 chain filled", 64'(newdat_vec), 64'h70);
    chk("R4 no loss yet", 64'(msglst_vec), 64'h0);
    send(29'h055, 0, 0, 4'd1, 64'hD);
    chk("R4 eob lost", 64'(msglst_vec), 64'h40);
    peek(6);
    chk("R4 eob overwritten", rd_data, 64'hD);
    peek(4);
    chk("R4 head kept", rd_data, 64'hA);
    chk("R8 int_id obj5", 64'(int_id), 64'd5);
    clear(4, 4'b0011);
    chk("R10 clear newdat+pend", 64'(newdat_vec), 64'h60);
    chk("R10 int_id moves", 64'(int_id), 64'd6);
    send(29'h055, 0, 0, 4'd1, 64'hE);
    peek(4);
    chk("R4 refill lowest", rd_data, 64'hE);
    chk("R4 refill no loss", 64'(msglst_vec), 64'h40);
    clear(6, 4'b0100);
    chk("R10 clear lost", 64'(msglst_vec), 64'h0);
  endtask

  task automatic t_drop();
    do_reset();
    set_obj(8, 0, 29'h200, 0, '0, 1, 0);
    send(29'h200, 0, 0, 4'd3, 64'h1111);
    send(29'h200, 0, 0, 4'd3, 64'h2222);
    peek(8);
    chk("R5 dropped data", rd_data, 64'h1111);
    chk("R5 no loss", 64'(msglst_vec), 64'h0);
    chk("R5 newdat", 64'(newdat_vec), 64'h100);
  endtask

  task automatic t_rxie();
    do_reset();
    set_obj(9, 0, 29'h300, 0, '0, 0, 1);
    send(29'h300, 0, 0, 4'd1, 64'h9);
    chk("R6 newdat set", 64'(newdat_vec), 64'h200);
    chk("R6 no pending", 64'(intpnd_vec), 64'h0);
    chk("R6 int_id 0", 64'(int_id), 64'h0);
  endtask

  task automatic t_prio();
    do_reset();
    set_obj(3, 0, 29'h3A0, 0, '0, 1, 1);
    set_obj(10, 0, 29'h3A1, 0, '0, 1, 1);
    send(29'h3A1, 0, 0, 4'd1, 64'h1);
    chk("R8 single pending", 64'(int_id), 64'd11);
    send(29'h3A0, 0, 0, 4'd1, 64'h2);
    chk("R8 lowest of two", 64'(int_id), 64'd4);
    @(negedge clk);
    stat_irq = 1; #1;
    chk("R7 status wins", 64'(int_id), 64'h8000);
    stat_irq = 0;
    clear(3, 4'b0010);
    chk("R8 after clear", 64'(int_id), 64'd11);
    clear(10, 4'b0010);
    chk("R8 none pending", 64'(int_id), 64'd0);
  endtask

  task automatic t_remote();
    do_reset();
    set_obj(12, 1, 29'h0AB, 0, '0, 1, 1);
    set_obj(13, 0, 29'h0AB, 0, '0, 1, 1);
    send(29'h0AB, 0, 1, 4'd4, 64'hDEAD);
    chk("R9 txrqst", 64'(txrqst_vec), 64'h1000);
    chk("R9 no newdat", 64'(newdat_vec), 64'h0);
    peek(12);
    chk("R9 no payload", rd_data, 64'h0);
    send(29'h0AB, 0, 0, 4'd4, 64'hBEEF);
    chk("R9 data to rx obj", 64'(newdat_vec), 64'h2000);
    clear(12, 4'b1000);
    chk("R10 clear txrqst", 64'(txrqst_vec), 64'h0);
    set_obj(13, 0, 29'h0AB, 0, '0, 1, 1);
    chk("R11 cfg clears newdat", 64'(newdat_vec), 64'h0);
    chk("R11 cfg clears pend", 64'(intpnd_vec), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_exact();
    t_mask();
    t_fifo();
    t_drop();
    t_rxie();
    t_prio();
    t_remote();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule